// File: doc/BRIEF.md
# Host Register Bank for a Parallel Storage Bus Controller

This block is the byte-wide register bank that a host processor sees when it talks to a parallel storage bus controller. The host presents a four-bit register index and a read or write strobe; eight index values are decoded, and the same index reaches one register on a read and a different one on a write. The bank holds the initiator command, mode, target command, ID-select and output-data registers, drives the initiator's bus control lines from the initiator command, and assembles the control-line and bus-status read values from the live bus lines.

The bank also watches the three bus phase lines (message, command/data, input/output) and compares them with the phase the host expects. In DMA mode a change from a matching to a non-matching phase raises an interrupt. Writes to the DMA start slots give a one-cycle DMA request strobe and set a DMA request flag, which a transferred DMA byte clears. There is no streaming data path here. The host port is a plain strobe interface with no back-pressure: every strobe is accepted in the cycle it is given.

Top module: `sbc_host_regs`

## Requirements
- R1: After reset every register is zero, all driven bus lines, the DMA strobe, the send-armed flag and the interrupt are low, and the arbitration phase is not active.
- R2: Index values 8 to 15 are ignored by writes and read as 0x00. A read of index 0 returns the live data bus lines.
- R3: Index 1 written sets the driven lines from the byte: bit7 reset, bit4 acknowledge, bit3 busy, bit2 select, bit1 attention, bit0 data-bus enable. Bits 6 and 5 of a written byte are not stored. Reading index 1 returns the stored bits, with bit5 zero.
- R4: A write of the mode register (index 2) with bit0 set enters arbitration and sets the arbitration flag. The first index-1 read afterwards shows bit6 set and clears the flag, so the next read shows bit6 clear. A mode write with bit0 clear leaves arbitration and clears the flag.
- R5: Index 3 stores only bits [3:0] of a written byte (bit3 request, bit2 message, bit1 command/data, bit0 input/output). Reads return those bits, with bits [7:4] zero.
- R6: Index 4 read returns {reset driven, busy (driven OR bus busy line), request line, message line, command/data line, input/output line, select driven, parity line} from bit7 down to bit0.
- R7: Index 5 read returns bit0 acknowledge driven, bit1 attention driven, bit3 phase match, bit4 interrupt pending, bit6 DMA request flag, and all other bits zero. Phase match is high when {message, command/data, input/output} equals target command bits [2:0].
- R8: Index 2 reads back the full mode byte last written. Bit1 of the mode byte enables DMA mode.
- R9: A write of index 5 or index 7 makes `drq_pulse_o` high for exactly the next cycle; a write of index 6 does not. An index-5 write sets `send_armed_o`. A mode write with bit1 clear clears `send_armed_o`.
- R10: The DMA request flag (status bit6) is set by an index-5 or index-7 write and cleared by `dma_xfer_i`. If both happen in the same cycle, the set wins.
- R11: With mode bit1 set, a phase match that falls from 1 to 0 sets `irq_o`. A read of index 6 or index 7 returns 0x00 and clears `irq_o`.
- R12: Read data appears on `host_rdata_o` one cycle after the read strobe and holds until the next read. Write effects appear one cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_idx_i | input | 4 | Register index (host address bits 7..4) |
| host_wr_i | input | 1 | Write strobe |
| host_rd_i | input | 1 | Read strobe |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Registered read data |
| bus_data_i | input | 8 | Live data bus lines |
| bus_bsy_i | input | 1 | Busy line driven by the target |
| bus_req_i | input | 1 | Request line |
| bus_msg_i | input | 1 | Message phase line |
| bus_cd_i | input | 1 | Command/data phase line |
| bus_io_i | input | 1 | Input/output phase line |
| bus_parity_i | input | 1 | Parity line |
| drv_rst_o | output | 1 | Drive bus reset |
| drv_ack_o | output | 1 | Drive acknowledge |
| drv_bsy_o | output | 1 | Drive busy |
| drv_sel_o | output | 1 | Drive select |
| drv_atn_o | output | 1 | Drive attention |
| drv_dben_o | output | 1 | Enable the output data onto the bus |
| out_data_o | output | 8 | Output data register |
| id_sel_o | output | 8 | ID-select register |
| arb_active_o | output | 1 | Arbitration phase active |
| drq_pulse_o | output | 1 | One-cycle DMA request strobe |
| send_armed_o | output | 1 | DMA send armed |
| dma_xfer_i | input | 1 | One DMA byte transferred |
| irq_o | output | 1 | Interrupt pending |

## Verification
Every write effect (driven lines, armed flag, DMA strobe, arbitration state) is due one cycle after the write strobe. Read data is due one cycle after the read strobe. The interrupt rises one cycle after the phase lines change. The bench drives strobes at the falling edge and samples at the next falling edge, so each check falls exactly one rising edge after its stimulus. The strobe is checked once more a cycle later to show that it lasts a single cycle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [2:0] {
    RS_BUSDATA = 3'd0, RS_ICMD = 3'd1, RS_MODE = 3'd2, RS_TCMD = 3'd3,
    RS_CTRL = 3'd4, RS_STAT = 3'd5, RS_INDATA = 3'd6, RS_ACKIRQ = 3'd7
  } rd_slot_e;

  typedef enum logic [2:0] {
    WS_OUTDATA = 3'd0, WS_ICMD = 3'd1, WS_MODE = 3'd2, WS_TCMD = 3'd3,
    WS_IDSEL = 3'd4, WS_DMA_SEND = 3'd5, WS_DMA_TRX = 3'd6, WS_DMA_IRX = 3'd7
  } wr_slot_e;

  localparam int IC_RST  = 7;
  localparam int IC_ARB  = 6;
  localparam int IC_ACK  = 4;
  localparam int IC_BSY  = 3;
  localparam int IC_SEL  = 2;
  localparam int IC_ATN  = 1;
  localparam int IC_DBUS = 0;
  localparam logic [7:0] IC_STORE_MASK = 8'b1001_1111;

  localparam int MD_ARB = 0;
  localparam int MD_DMA = 1;
endpackage

// File: rtl/sbc_ctrl_regs.sv
module sbc_ctrl_regs
  import sbc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TCMD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  wr_slot_e          wr_slot,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_stb,
  input  rd_slot_e          rd_slot,
  output logic [DATA_W-1:0] icmd_q,
  output logic [DATA_W-1:0] mode_q,
  output logic [TCMD_W-1:0] tcmd_q,
  output logic [DATA_W-1:0] idsel_q,
  output logic [DATA_W-1:0] outdata_q,
  output logic              arb_flag_q,
  output logic              arb_active_q
);
  logic mode_wr;
  assign mode_wr = wr_stb && (wr_slot == WS_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icmd_q    <= '0;
      mode_q    <= '0;
      tcmd_q    <= '0;
      idsel_q   <= '0;
      outdata_q <= '0;
    end else if (wr_stb) begin
      case (wr_slot)
        WS_OUTDATA: outdata_q <= wdata;
        WS_ICMD:    icmd_q    <= wdata & IC_STORE_MASK;
        WS_MODE:    mode_q    <= wdata;
        WS_TCMD:    tcmd_q    <= wdata[TCMD_W-1:0];
        WS_IDSEL:   idsel_q   <= wdata;
        default:    ;
      endcase
    end
  end

  // Arbitration phase and its self-clearing flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arb_flag_q   <= 1'b0;
      arb_active_q <= 1'b0;
    end else if (mode_wr) begin
      arb_active_q <= wdata[MD_ARB];
      arb_flag_q   <= wdata[MD_ARB];
    end else if (rd_stb && (rd_slot == RS_ICMD)) begin
      arb_flag_q <= 1'b0;
    end
  end

  assert_arb_flag_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_slot == RS_ICMD && !mode_wr) |=> !arb_flag_q);

  assert_arb_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && wdata[MD_ARB]) |=> (arb_flag_q && arb_active_q));
endmodule

// File: rtl/sbc_phase_mon.sv
module sbc_phase_mon #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] bus_phase,
  input  logic [PH_W-1:0] exp_phase,
  input  logic            dma_mode,
  input  logic            irq_clr,
  output logic            phase_match,
  output logic            irq_q
);
  logic pm_q;
  logic irq_set;

  assign phase_match = (bus_phase == exp_phase);
  assign irq_set     = dma_mode && pm_q && !phase_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      pm_q <= phase_match;
      if (irq_set)      irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !irq_q);

  assert_irq_needs_dma_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_mode && !irq_q) |=> !irq_q);
endmodule

// File: rtl/sbc_dma_ctl.sv
module sbc_dma_ctl
  import sbc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_stb,
  input  wr_slot_e wr_slot,
  input  logic     wdata_dma_bit,
  input  logic     dma_xfer,
  output logic     drq_pulse_q,
  output logic     drq_flag_q,
  output logic     send_armed_q
);
  logic start;
  assign start = wr_stb && ((wr_slot == WS_DMA_SEND) || (wr_slot == WS_DMA_IRX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drq_pulse_q  <= 1'b0;
      drq_flag_q   <= 1'b0;
      send_armed_q <= 1'b0;
    end else begin
      drq_pulse_q <= start;
      if (start)         drq_flag_q <= 1'b1;
      else if (dma_xfer) drq_flag_q <= 1'b0;
      if (wr_stb && wr_slot == WS_DMA_SEND)                send_armed_q <= 1'b1;
      else if (wr_stb && wr_slot == WS_MODE && !wdata_dma_bit) send_armed_q <= 1'b0;
    end
  end

  assert_drq_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> drq_pulse_q);

  assert_drq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !drq_pulse_q);

  assert_drq_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_xfer && !start) |=> !drq_flag_q);
endmodule

// File: rtl/sbc_host_regs.sv
module sbc_host_regs
  import sbc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  host_idx_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_bsy_i,
  input  logic              bus_req_i,
  input  logic              bus_msg_i,
  input  logic              bus_cd_i,
  input  logic              bus_io_i,
  input  logic              bus_parity_i,
  output logic              drv_rst_o,
  output logic              drv_ack_o,
  output logic              drv_bsy_o,
  output logic              drv_sel_o,
  output logic              drv_atn_o,
  output logic              drv_dben_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [DATA_W-1:0] id_sel_o,
  output logic              arb_active_o,
  output logic              drq_pulse_o,
  output logic              send_armed_o,
  input  logic              dma_xfer_i,
  output logic              irq_o
);
  localparam int SLOT_W = 3;
  localparam int TCMD_W = 4;
  localparam int PH_W   = 3;

  logic     idx_ok;
  logic     wr_stb, rd_stb;
  wr_slot_e wr_slot;
  rd_slot_e rd_slot;

  assign idx_ok  = (host_idx_i[IDX_W-1:SLOT_W] == '0);
  assign wr_stb  = host_wr_i && idx_ok;
  assign rd_stb  = host_rd_i && idx_ok;
  assign wr_slot = wr_slot_e'(host_idx_i[SLOT_W-1:0]);
  assign rd_slot = rd_slot_e'(host_idx_i[SLOT_W-1:0]);

  logic [DATA_W-1:0] icmd_q, mode_q, idsel_q, outdata_q;
  logic [TCMD_W-1:0] tcmd_q;
  logic              arb_flag_q, arb_active_q;

  sbc_ctrl_regs #(.DATA_W(DATA_W), .TCMD_W(TCMD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_slot(wr_slot),
    .wdata(host_wdata_i), .rd_stb(rd_stb), .rd_slot(rd_slot),
    .icmd_q(icmd_q), .mode_q(mode_q), .tcmd_q(tcmd_q), .idsel_q(idsel_q),
    .outdata_q(outdata_q), .arb_flag_q(arb_flag_q), .arb_active_q(arb_active_q)
  );

  logic phase_match, irq_q, irq_clr;
  assign irq_clr = rd_stb && ((rd_slot == RS_INDATA) || (rd_slot == RS_ACKIRQ));

  sbc_phase_mon #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .bus_phase({bus_msg_i, bus_cd_i, bus_io_i}),
    .exp_phase(tcmd_q[PH_W-1:0]),
    .dma_mode(mode_q[MD_DMA]), .irq_clr(irq_clr),
    .phase_match(phase_match), .irq_q(irq_q)
  );

  logic drq_pulse_q, drq_flag_q, send_armed_q;

  sbc_dma_ctl u_dma (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_slot(wr_slot),
    .wdata_dma_bit(host_wdata_i[MD_DMA]), .dma_xfer(dma_xfer_i),
    .drq_pulse_q(drq_pulse_q), .drq_flag_q(drq_flag_q), .send_armed_q(send_armed_q)
  );

  // Driven lines come straight from the stored initiator command
  assign drv_rst_o    = icmd_q[IC_RST];
  assign drv_ack_o    = icmd_q[IC_ACK];
  assign drv_bsy_o    = icmd_q[IC_BSY];
  assign drv_sel_o    = icmd_q[IC_SEL];
  assign drv_atn_o    = icmd_q[IC_ATN];
  assign drv_dben_o   = icmd_q[IC_DBUS];
  assign out_data_o   = outdata_q;
  assign id_sel_o     = idsel_q;
  assign arb_active_o = arb_active_q;
  assign drq_pulse_o  = drq_pulse_q;
  assign send_armed_o = send_armed_q;
  assign irq_o        = irq_q;

  // Read value assembly
  logic [DATA_W-1:0] icmd_rd, ctrl_rd, stat_rd, rd_val;

  always_comb begin
    icmd_rd         = icmd_q;
    icmd_rd[IC_ARB] = arb_flag_q;
  end

  assign ctrl_rd = {drv_rst_o, (drv_bsy_o | bus_bsy_i), bus_req_i, bus_msg_i,
                    bus_cd_i, bus_io_i, drv_sel_o, bus_parity_i};
  assign stat_rd = {1'b0, drq_flag_q, 1'b0, irq_q, phase_match, 1'b0,
                    drv_atn_o, drv_ack_o};

  always_comb begin
    rd_val = '0;
    if (idx_ok) begin
      case (rd_slot)
        RS_BUSDATA: rd_val = bus_data_i;
        RS_ICMD:    rd_val = icmd_rd;
        RS_MODE:    rd_val = mode_q;
        RS_TCMD:    rd_val = {{(DATA_W-TCMD_W){1'b0}}, tcmd_q};
        RS_CTRL:    rd_val = ctrl_rd;
        RS_STAT:    rd_val = stat_rd;
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         host_rdata_o <= '0;
    else if (host_rd_i) host_rdata_o <= rd_val;
  end

  assert_icmd_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_slot == WS_ICMD) |=>
      (drv_ack_o == $past(host_wdata_i[4])) && (drv_rst_o == $past(host_wdata_i[7])));

  assert_tcmd_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_slot == RS_TCMD) |=> (host_rdata_o[7:4] == 4'h0));

  assert_irq_slot_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> (host_rdata_o == '0));

  assert_bad_index_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && !idx_ok) |=> (host_rdata_o == '0));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_i |=> $stable(host_rdata_o));
endmodule

// File: tb/sbc_host_regs_tb.sv
module sbc_host_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_idx_i = '0;
  logic       host_wr_i = 1'b0, host_rd_i = 1'b0;
  logic [7:0] host_wdata_i = '0, host_rdata_o;
  logic [7:0] bus_data_i = '0;
  logic bus_bsy_i = 0, bus_req_i = 0, bus_msg_i = 0, bus_cd_i = 0, bus_io_i = 0, bus_parity_i = 0;
  logic drv_rst_o, drv_ack_o, drv_bsy_o, drv_sel_o, drv_atn_o, drv_dben_o;
  logic [7:0] out_data_o, id_sel_o;
  logic arb_active_o, drq_pulse_o, send_armed_o, irq_o;
  logic dma_xfer_i = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sbc_host_regs dut_i (.*);

  // Vector format: {write index, write data, read index, expected read}
  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    {4'h1, 8'h9F, 4'h1, 8'h9F},  // R3 stored bits read back
    {4'h1, 8'h7F, 4'h1, 8'h1F},  // R3 bits 6 and 5 not stored
    {4'h2, 8'hA4, 4'h2, 8'hA4},  // R8 mode read back
    {4'h3, 8'hFA, 4'h3, 8'h0A},  // R5 low nibble only
    {4'h1, 8'h84, 4'h4, 8'h82},  // R6 reset and select in control read
    {4'h1, 8'h12, 4'h5, 8'h03},  // R7 ack, atn, phase mismatch
    {4'h3, 8'h08, 4'h5, 8'h0B},  // R7 phase match
    {4'h9, 8'hFF, 4'h2, 8'hA4},  // R2 high index write ignored
    {4'h0, 8'h5A, 4'hA, 8'h00}   // R2 high index reads zero
  };

  task automatic check(input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    host_idx_i = idx; host_wdata_i = d; host_wr_i = 1'b1;
    @(negedge clk);
    host_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] d);
    @(negedge clk);
    host_idx_i = idx; host_rd_i = 1'b1;
    @(negedge clk);
    host_rd_i = 1'b0;
    d = host_rdata_o;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 driven lines", {drv_rst_o, drv_ack_o, drv_bsy_o, drv_sel_o, drv_atn_o, drv_dben_o}, 8'h00);
    check("R1 flags", {arb_active_o, drq_pulse_o, send_armed_o, irq_o}, 8'h00);
    rd(4'h1, r); check("R1 icmd", r, 8'h00);
    rd(4'h2, r); check("R1 mode", r, 8'h00);
    rd(4'h5, r); check("R1 status", r, 8'h08);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][23:20], VEC[k][19:12]);
      rd(VEC[k][11:8], r);
      check($sformatf("vector %0d", k), r, VEC[k][7:0]);
    end
    check("R2 output data", out_data_o, 8'h5A);

    // R2 index 0 reads live data bus
    bus_data_i = 8'hC3;
    rd(4'h0, r); check("R2 data bus", r, 8'hC3);

    // R3 driven lines
    wr(4'h1, 8'h9F);
    check("R3 lines on", {drv_rst_o, drv_ack_o, drv_bsy_o, drv_sel_o, drv_atn_o, drv_dben_o}, 8'h3F);
    wr(4'h1, 8'h00);
    check("R3 lines off", {drv_rst_o, drv_ack_o, drv_bsy_o, drv_sel_o, drv_atn_o, drv_dben_o}, 8'h00);

    // R4 arbitration flag
    wr(4'h2, 8'h01);
    check("R4 arb active", {7'b0, arb_active_o}, 8'h01);
    rd(4'h1, r); check("R4 first read", r, 8'h40);
    rd(4'h1, r); check("R4 second read", r, 8'h00);
    wr(4'h2, 8'h00);
    check("R4 arb left", {7'b0, arb_active_o}, 8'h00);

    // R6 control read from live lines
    bus_bsy_i = 1; bus_req_i = 1; bus_msg_i = 1; bus_io_i = 1; bus_parity_i = 1;
    rd(4'h4, r); check("R6 control", r, 8'h75);
    bus_bsy_i = 0; bus_req_i = 0; bus_msg_i = 0; bus_io_i = 0; bus_parity_i = 0;

    // R9 and R10 DMA start
    wr(4'h5, 8'h00);
    check("R9 strobe high", {7'b0, drq_pulse_o}, 8'h01);
    check("R9 send armed", {7'b0, send_armed_o}, 8'h01);
    @(negedge clk);
    check("R9 strobe one cycle", {7'b0, drq_pulse_o}, 8'h00);
    rd(4'h5, r); check("R10 flag set", r, 8'h48);
    @(negedge clk); dma_xfer_i = 1'b1;
    @(negedge clk); dma_xfer_i = 1'b0;
    rd(4'h5, r); check("R10 flag cleared", r, 8'h08);
    wr(4'h6, 8'h00);
    check("R9 index 6 no strobe", {7'b0, drq_pulse_o}, 8'h00);
    rd(4'h5, r); check("R10 index 6 no flag", r, 8'h08);
    wr(4'h7, 8'h00);
    check("R9 index 7 strobe", {7'b0, drq_pulse_o}, 8'h01);

    // R11 interrupt on phase mismatch in DMA mode
    wr(4'h2, 8'h02);
    check("R9 armed kept", {7'b0, send_armed_o}, 8'h01);
    @(negedge clk); bus_io_i = 1'b1;
    @(negedge clk);
    check("R11 irq set", {7'b0, irq_o}, 8'h01);
    rd(4'h5, r); check("R11 status", r, 8'h50);
    rd(4'h7, r); check("R11 slot 7 zero", r, 8'h00);
    check("R11 irq cleared", {7'b0, irq_o}, 8'h00);
    rd(4'h6, r); check("R11 slot 6 zero", r, 8'h00);
    bus_io_i = 1'b0;

    // R12 read data holds
    rd(4'h2, r);
    repeat (3) @(negedge clk);
    check("R12 hold", host_rdata_o, 8'h02);

    // R9 arm cleared by mode write with bit1 clear
    wr(4'h2, 8'h00);
    check("R9 armed cleared", {7'b0, send_armed_o}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule